// File: doc/BRIEF.md
# Tone Detect Guard Time Qualifier

This block is a digital stand-in for the resistor–capacitor timing network that sits after a dual-tone alert detector. It takes the raw early-steer indication, which is high only while both the low and the high alert tones are being heard. It then produces an active-low steering output. Steering asserts only once the raw indication has stayed present for a programmable present guard time. It releases only once the raw indication has stayed absent for a separately programmable absent guard time. All times are counted in ticks of an external 1 ms strobe. The total recognition time is therefore the detector's own latency plus the present guard, and the total absent time is the detector latency plus the absent guard. For example, an absent guard of 15 ticks with a detector latency of up to 10 ms gives 15 to 25 ms.

A second stage grades each qualified steering pulse. It measures the pulse length in ticks and the longest dropout of the raw indication inside it. When steering releases, it raises a one-clock valid flag if the pulse passed every limit and a one-clock invalid flag if it failed any of them. A disable input parks the block. The raw input passes through a parameterised synchroniser and is mirrored on an output.

Top module: `tone_guard_qual`

## Requirements
- R1: During and straight after reset, `std_n_o` is 1, `valid_o` and `invalid_o` are 0, and `est_o` is 0.
- R2: `std_n_o` falls at the clock edge of the tick on which the synchronised raw input has been high for `pres_gt_i` consecutive ticks. Here a tick is a clock with `tick_i` high, and the synchronised input is `est_i` delayed by SYNC_STAGES clocks.
- R3: `std_n_o` rises at the clock edge of the tick on which the synchronised raw input has been low for `abs_gt_i` consecutive ticks while steering is asserted.
- R4: If the raw input returns to the current steering state before its guard expires, the guard count restarts from zero. Bursts shorter than the guard therefore never move `std_n_o`.
- R5: The present and absent guards act independently of each other. A guard value of 0 behaves like 1.
- R6: When steering releases, `valid_o` is high for exactly that one clock if all three of these hold: the pulse length is at least `min_len_i`; the pulse length is at most `max_len_i`; and the longest completed internal dropout is at most `max_drop_i` ticks. The pulse length counts the ticks seen while `std_n_o` was low, including the releasing tick.
- R7: When steering releases and any limit of R6 is broken, `invalid_o` is high for that one clock instead. The two flags are never high together.
- R8: While `dis_i` is high, `std_n_o` is 1 from the next clock, all counters are cleared, no flag is raised, and `est_o` is 0.
- R9: With `dis_i` low, `est_o` equals `est_i` delayed by SYNC_STAGES clocks.
- R10: The pulse length and dropout counters saturate at the all-ones value of TW bits rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_i | input | 1 | Disable: parks steering and clears counters |
| tick_i | input | 1 | One-clock 1 ms time base strobe |
| est_i | input | 1 | Raw early-steer input, high while both tones are present |
| pres_gt_i | input | TW | Present guard time in ticks |
| abs_gt_i | input | TW | Absent guard time in ticks |
| min_len_i | input | TW | Shortest acceptable steering pulse in ticks |
| max_len_i | input | TW | Longest acceptable steering pulse in ticks |
| max_drop_i | input | TW | Longest acceptable internal dropout in ticks |
| est_o | output | 1 | Synchronised mirror of the raw input, low while disabled |
| std_n_o | output | 1 | Guard-qualified steering, active low |
| valid_o | output | 1 | One-clock pulse: qualified pulse met every limit |
| invalid_o | output | 1 | One-clock pulse: qualified pulse broke a limit |

## Verification
The hardest state to reach is a dropout long enough to break the dropout limit yet short enough not to end the pulse. The stimulus widens the absent guard above the dropout limit, then cuts the raw tone for a span between the two. The other hard case is length saturation, which needs a pulse of more than 255 ticks. That is reached by holding the tone for 300 ticks with very short guards and an upper limit of 255, so that a wrapping counter would grade the pulse invalid. Raw hold times are whole multiples of the tick period, so every window contains a known number of ticks, and the behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/tgq_pkg.sv
package tgq_pkg;
   typedef enum logic {
      PH_QUIET = 1'b0,
      PH_TONE  = 1'b1
   } tgq_phase_e;
endpackage

// File: rtl/tgq_sync.sv
module tgq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d_i;
            else chain <= {chain[STAGES-2:0], d_i};
         end
         assign q_o = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tgq_guard.sv
module tgq_guard
   import tgq_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dis_i,
   input  logic          tick_i,
   input  logic          tone_i,
   input  logic [TW-1:0] pres_i,
   input  logic [TW-1:0] abs_i,
   output logic          qual_o,
   output logic          rel_o
);
   tgq_phase_e    phase;
   logic [TW-1:0] cnt;
   logic [TW-1:0] limit;
   logic          differs;
   logic          expire;

   assign limit   = (phase == PH_TONE) ? abs_i : pres_i;
   assign differs = tone_i != (phase == PH_TONE);
   assign expire  = tick_i && ({1'b0, cnt} + 1'b1 >= {1'b0, limit});
   assign rel_o   = !dis_i && (phase == PH_TONE) && differs && expire;
   assign qual_o  = (phase == PH_TONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_QUIET;
         cnt   <= '0;
      end else if (dis_i) begin
         phase <= PH_QUIET;
         cnt   <= '0;
      end else if (!differs) begin
         cnt <= '0;
      end else if (tick_i) begin
         if (expire) begin
            phase <= (phase == PH_TONE) ? PH_QUIET : PH_TONE;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tgq_pulse_check.sv
module tgq_pulse_check #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dis_i,
   input  logic          tick_i,
   input  logic          qual_i,
   input  logic          tone_i,
   input  logic          rel_i,
   input  logic [TW-1:0] min_i,
   input  logic [TW-1:0] max_i,
   input  logic [TW-1:0] mdrop_i,
   output logic          valid_o,
   output logic          invalid_o
);
   localparam logic [TW-1:0] SAT = {TW{1'b1}};

   logic [TW-1:0] len_q, drop_q, worst_q;
   logic [TW-1:0] len_inc, drop_inc;
   logic          pass;

   assign len_inc  = (len_q == SAT) ? SAT : len_q + 1'b1;
   assign drop_inc = (drop_q == SAT) ? SAT : drop_q + 1'b1;
   assign pass     = (len_inc >= min_i) && (len_inc <= max_i) && (worst_q <= mdrop_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q   <= '0;
         drop_q  <= '0;
         worst_q <= '0;
      end else if (dis_i || !qual_i) begin
         len_q   <= '0;
         drop_q  <= '0;
         worst_q <= '0;
      end else if (tick_i) begin
         len_q <= len_inc;
         if (!tone_i) begin
            drop_q <= drop_inc;
         end else begin
            if (drop_q > worst_q) worst_q <= drop_q;
            drop_q <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o   <= 1'b0;
         invalid_o <= 1'b0;
      end else begin
         valid_o   <= rel_i && pass;
         invalid_o <= rel_i && !pass;
      end
   end
endmodule

// File: rtl/tone_guard_qual.sv
module tone_guard_qual #(
   parameter int TW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dis_i,
   input  logic          tick_i,
   input  logic          est_i,
   input  logic [TW-1:0] pres_gt_i,
   input  logic [TW-1:0] abs_gt_i,
   input  logic [TW-1:0] min_len_i,
   input  logic [TW-1:0] max_len_i,
   input  logic [TW-1:0] max_drop_i,
   output logic          est_o,
   output logic          std_n_o,
   output logic          valid_o,
   output logic          invalid_o
);
   generate
      if (TW < 2 || TW > 24) begin : g_bad_tw
         $error("tone_guard_qual: TW out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tone_guard_qual: SYNC_STAGES out of range");
      end
   endgenerate

   logic tone_s;
   logic qual;
   logic rel;

   tgq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (est_i),
      .q_o   (tone_s)
   );

   tgq_guard #(.TW(TW)) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .dis_i  (dis_i),
      .tick_i (tick_i),
      .tone_i (tone_s),
      .pres_i (pres_gt_i),
      .abs_i  (abs_gt_i),
      .qual_o (qual),
      .rel_o  (rel)
   );

   tgq_pulse_check #(.TW(TW)) u_check (
      .clk       (clk),
      .rst_n     (rst_n),
      .dis_i     (dis_i),
      .tick_i    (tick_i),
      .qual_i    (qual),
      .tone_i    (tone_s),
      .rel_i     (rel),
      .min_i     (min_len_i),
      .max_i     (max_len_i),
      .mdrop_i   (max_drop_i),
      .valid_o   (valid_o),
      .invalid_o (invalid_o)
   );

   assign est_o   = dis_i ? 1'b0 : tone_s;
   assign std_n_o = ~qual;
endmodule

// File: rtl/tgq_checker.sv
module tgq_checker (
   input logic clk,
   input logic rst_n,
   input logic dis_i,
   input logic tick_i,
   input logic est_o,
   input logic std_n_o,
   input logic valid_o,
   input logic invalid_o
);
   p_std_moves_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (std_n_o != $past(std_n_o)) |-> ($past(tick_i) || $past(dis_i)));

   p_dis_parks_std_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |=> std_n_o);

   p_dis_mirror_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dis_i |-> !est_o);

   p_flag_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o || invalid_o) |-> $rose(std_n_o));

   p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_o && invalid_o));

   p_flag_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o || invalid_o) |=> !(valid_o || invalid_o));
endmodule

bind tone_guard_qual tgq_checker u_tgq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .dis_i     (dis_i),
   .tick_i    (tick_i),
   .est_o     (est_o),
   .std_n_o   (std_n_o),
   .valid_o   (valid_o),
   .invalid_o (invalid_o)
);

// File: tb/test_tone_guard_qual.sv
`timescale 1ns/1ps
module test_tone_guard_qual;
   localparam int TW = 8;
   localparam int TICK_PER = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dis = 1'b0, tick = 1'b0, est = 1'b0;
   logic [TW-1:0] pr = 8'd3, ab = 8'd4, mn = 8'd5, mx = 8'd12, md = 8'd2;
   logic est_o, std_n, valid, invalid;

   always #4 clk = ~clk;

   tone_guard_qual #(.TW(TW), .SYNC_STAGES(2)) i_tone_guard_qual (
      .clk(clk), .rst_n(rst_n), .dis_i(dis), .tick_i(tick), .est_i(est),
      .pres_gt_i(pr), .abs_gt_i(ab), .min_len_i(mn), .max_len_i(mx), .max_drop_i(md),
      .est_o(est_o), .std_n_o(std_n), .valid_o(valid), .invalid_o(invalid));

   int vectors = 0, errors = 0, tcnt = 0;
   int n_val = 0, n_inv = 0, n_fall = 0;
   bit prev_std = 1'b1, done = 1'b0;

   // behavioural reference state
   int s1 = 0, s2 = 0, q = 0, c = 0, len = 0, drp = 0, worst = 0, ev = 0, ei = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_update();
      int es, lim, hit, rel, plen, pass;
      if (!rst_n) begin
         s1 = 0; s2 = 0; q = 0; c = 0; len = 0; drp = 0; worst = 0; ev = 0; ei = 0;
         return;
      end
      es   = s2;
      lim  = q ? int'(ab) : int'(pr);
      hit  = tick && (c + 1 >= lim);
      rel  = !dis && q && !es && hit;
      plen = (len + 1 > 255) ? 255 : len + 1;
      pass = (plen >= mn) && (plen <= mx) && (worst <= md);
      ev = rel && pass;
      ei = rel && !pass;
      if (dis || !q) begin
         len = 0; drp = 0; worst = 0;
      end else if (tick) begin
         len = plen;
         if (!es) drp = (drp + 1 > 255) ? 255 : drp + 1;
         else begin
            if (drp > worst) worst = drp;
            drp = 0;
         end
      end
      if (dis) begin q = 0; c = 0; end
      else if (es == q) c = 0;
      else if (tick) begin
         if (hit) begin q = !q; c = 0; end
         else c = c + 1;
      end
      s2 = s1; s1 = est;
   endtask

   task automatic compare();
      int exp_est;
      exp_est = dis ? 0 : s2;
      check(std_n == !q, "R2 std_n", std_n, !q);
      check(valid == ev, "R6 valid", valid, ev);
      check(invalid == ei, "R7 invalid", invalid, ei);
      check(est_o == exp_est, dis ? "R8 est_o" : "R9 est_o", est_o, exp_est);
      if (valid) n_val++;
      if (invalid) n_inv++;
      if (prev_std && !std_n) n_fall++;
      prev_std = std_n;
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      tcnt = (tcnt + 1) % TICK_PER;
      tick = (tcnt == 0);
   endtask

   task automatic hold(input bit e, input int ticks);
      est = e;
      repeat (ticks * TICK_PER) step();
   endtask

   task automatic cfg(input int p, input int a, input int lo, input int hi, input int d);
      pr = p[TW-1:0]; ab = a[TW-1:0]; mn = lo[TW-1:0]; mx = hi[TW-1:0]; md = d[TW-1:0];
      n_val = 0; n_inv = 0; n_fall = 0;
   endtask

   task automatic expect_flags(input string req, input int v, input int i);
      check(n_val == v, req, n_val, v);
      check(n_inv == i, req, n_inv, i);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset values
      repeat (3) begin
         @(negedge clk);
         check(std_n == 1'b1, "R1 std_n", std_n, 1);
         check(valid == 1'b0 && invalid == 1'b0, "R1 flags", valid | invalid, 0);
         check(est_o == 1'b0, "R1 est_o", est_o, 0);
      end
      rst_n = 1'b1;
      tick = 1'b1; tcnt = 0;
      hold(0, 4);

      // R4: bursts shorter than the present guard never assert steering
      cfg(3, 4, 5, 12, 2);
      hold(1, 2); hold(0, 1); hold(1, 2); hold(0, 1); hold(1, 2); hold(0, 10);
      check(n_fall == 0, "R4 no steering", n_fall, 0);
      expect_flags("R4 no flags", 0, 0);

      // R6: in-range pulse with a dropout equal to the limit
      cfg(3, 4, 5, 12, 2);
      hold(1, 4); hold(0, 2); hold(1, 4); hold(0, 10);
      check(n_fall == 1, "R2 one assertion", n_fall, 1);
      expect_flags("R6 valid pulse", 1, 0);

      // R7: dropout one tick over the limit
      cfg(3, 4, 5, 12, 2);
      hold(1, 4); hold(0, 3); hold(1, 4); hold(0, 10);
      expect_flags("R7 long dropout", 0, 1);

      // R7: too short
      cfg(3, 4, 5, 12, 2);
      hold(1, 3); hold(0, 10);
      expect_flags("R7 too short", 0, 1);

      // R7: too long
      cfg(3, 4, 5, 12, 2);
      hold(1, 20); hold(0, 10);
      expect_flags("R7 too long", 0, 1);

      // R5: zero present guard acts as one tick
      cfg(0, 1, 5, 12, 0);
      hold(1, 6); hold(0, 5);
      expect_flags("R5 zero guard", 1, 0);

      // R5: short present, long absent guard
      cfg(1, 6, 5, 12, 0);
      hold(1, 2); hold(0, 10);
      expect_flags("R5 long absent guard", 1, 0);

      // R5: long present guard rejects the same burst
      cfg(6, 1, 5, 12, 0);
      hold(1, 2); hold(0, 10);
      check(n_fall == 0, "R5 long present guard", n_fall, 0);
      expect_flags("R5 long present guard flags", 0, 0);

      // R8: disable mid-pulse, no flag, steering parked
      cfg(3, 4, 5, 12, 2);
      hold(1, 6);
      dis = 1'b1;
      hold(1, 3);
      check(std_n == 1'b1, "R8 std parked", std_n, 1);
      check(est_o == 1'b0, "R8 mirror low", est_o, 0);
      hold(0, 2);
      dis = 1'b0;
      hold(0, 8);
      expect_flags("R8 no flags", 0, 0);

      // R10: length saturates at 255 instead of wrapping
      cfg(1, 1, 250, 255, 0);
      hold(1, 300); hold(0, 4);
      expect_flags("R10 saturated length", 1, 0);

      // R3: release tick count after a fresh qualification
      cfg(2, 5, 1, 255, 0);
      hold(1, 4); hold(0, 4);
      check(std_n == 1'b0, "R3 still asserted", std_n, 0);
      hold(0, 2);
      check(std_n == 1'b1, "R3 released", std_n, 1);

      finish_run();
   end
endmodule